// File: doc/BRIEF.md
# ATA Status and Error Classifier

This block sorts one observation of a storage host's ATA register pair into a single fault category. Each observation carries the 8-bit STATUS and ERROR values, the command phase the host was in when it read them, and two flags from the host's command timer. The phase matters: the same STATUS bits are harmless in one phase and a protocol-state violation in another. The block returns a one-hot category and a suggested recovery action.

A host controller or error-handling sequencer pulses a strobe with the sampled values. One clock later the category, the action and a one-cycle valid pulse appear. Between strobes the outputs hold the last result. The block keeps no history. Sense-data parsing, log-page reads and retry counting are left to the consumer.

Phase codes on `phaseIn`: 0 before issue, 1 PIO data, 2 CDB transfer in progress, 3 after the last CDB byte, 4 completion, 5 NCQ commands outstanding, 6 packet command just issued, 7 idle. STATUS bit positions: BSY 7, DRDY 6, DRQ 3, ERR/CHK 0. ERROR bit positions: ICRC 7, UNC 6, IDNF 4, ABRT 2. Category bit positions on `catOut`: 0 no fault, 1 protocol violation, 2 bus transmission error, 3 NCQ error, 4 check condition, 5 media error, 6 address error, 7 other device error, 8 late completion, 9 unknown timeout. Action codes on `actOut`: 0 none, 1 report upward, 2 reset, 3 reset plus speed downgrade.

Top module: `ata_fault_sorter`

## Requirements
- R1: The outputs change only on the clock edge that samples `obsValid` high. `catValid` is high in exactly the following cycle, and `catOut` then has exactly one bit set. Without a strobe, `catOut` and `actOut` hold their values. After reset, `catOut`, `actOut` and `catValid` are all zero.
- R2: In phase 0, STATUS with BSY clear, DRDY set and DRQ clear gives category 0. Any other BSY/DRDY/DRQ combination gives category 1.
- R3: In phase 1, BSY clear together with DRQ clear gives category 1.
- R4: In phase 2, BSY clear with ERR set gives category 1.
- R5: In phase 4, DRQ set gives category 1.
- R6: In phase 3, BSY clear with CHK set gives category 4, whatever the ERROR byte holds.
- R7: In phase 5, BSY clear with ERR set gives category 3, whatever the ERROR byte holds.
- R8: In phases 1, 4 and 6, when BSY is clear, ERR is set and no violation applies, ICRC set gives category 2. This takes priority over every device-error subtype.
- R9: In the same case without ICRC, UNC gives category 5. Otherwise IDNF gives category 6. Otherwise the result is category 7, which covers an unsupported packet command (ABRT) in phase 6.
- R10: A strobe with `timedOut` set gives category 8 if `cmdDone` is set and category 9 otherwise, overriding every STATUS/ERROR rule.
- R11: The action is 3 for categories 1 and 2, 2 for categories 8 and 9, 1 for categories 3 to 7, and 0 for category 0.
- R12: Any strobe matching none of the rules above gives category 0, including every strobe in phase 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obsValid | input | 1 | Observation strobe |
| statusIn | input | 8 | STATUS register value |
| errorIn | input | 8 | ERROR register value |
| phaseIn | input | 3 | Command phase code |
| timedOut | input | 1 | Command timer expired |
| cmdDone | input | 1 | Command found complete at timeout |
| catOut | output | 10 | One-hot fault category |
| actOut | output | 2 | Suggested recovery action |
| catValid | output | 1 | Result valid, one cycle after strobe |

## Verification
The cases hardest to reach are rule overlaps: an observation that satisfies a violation rule, the ICRC rule and a device subtype at once, or a timeout arriving together with a violating STATUS. The stimulus reaches every such overlap by crossing every phase with all sixteen combinations of the decisive STATUS bits, all sixteen of the decisive ERROR bits, and the three timer states. Bits that no rule reads are filled with a changing pattern, which shows they do not alter the result.

// File: rtl/fault_sort_pkg.sv
package fault_sort_pkg;
  localparam int REG_W   = 8;
  localparam int PHASE_W = 3;
  localparam int NUM_CAT = 10;
  localparam int ACT_W   = 2;
  localparam int CAT_IW  = $clog2(NUM_CAT);

  // STATUS / ERROR bit positions fixed by the device protocol
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;
  localparam int ER_ICRC = 7;
  localparam int ER_UNC  = 6;
  localparam int ER_IDNF = 4;

  localparam int CAT_OK    = 0;
  localparam int CAT_HSM   = 1;
  localparam int CAT_BUS   = 2;
  localparam int CAT_NCQ   = 3;
  localparam int CAT_CHK   = 4;
  localparam int CAT_MEDIA = 5;
  localparam int CAT_ADDR  = 6;
  localparam int CAT_OTHER = 7;
  localparam int CAT_LATE  = 8;
  localparam int CAT_UNK   = 9;

  typedef enum logic [PHASE_W-1:0] {
    PH_PRE = 3'd0, PH_PIO = 3'd1, PH_CDB = 3'd2, PH_POST = 3'd3,
    PH_DONE = 3'd4, PH_NCQ = 3'd5, PH_PKT = 3'd6, PH_IDLE = 3'd7
  } phase_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 2'd0, ACT_REPORT = 2'd1, ACT_RESET = 2'd2, ACT_RESET_SLOW = 2'd3
  } action_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic timeout;
    logic late;
    logic phPre;
    logic phPio;
    logic phCdb;
    logic phPost;
    logic phDone;
    logic phNcq;
    logic phPkt;
  } sortCtl_t;

  function automatic action_e actionFor(input logic [CAT_IW-1:0] idx);
    case (idx)
      CAT_OK:             return ACT_NONE;
      CAT_HSM, CAT_BUS:   return ACT_RESET_SLOW;
      CAT_LATE, CAT_UNK:  return ACT_RESET;
      default:            return ACT_REPORT;
    endcase
  endfunction
endpackage

// File: rtl/fault_sort_ctrl.sv
module fault_sort_ctrl
  import fault_sort_pkg::*;
(
  input  logic               obsValid,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic               timedOut,
  input  logic               cmdDone,
  output sortCtl_t           ctl
);
  phase_e ph;
  assign ph = phase_e'(phaseIn);

  always_comb begin
    ctl         = '0;
    ctl.capture = obsValid;
    ctl.timeout = timedOut;
    ctl.late    = timedOut & cmdDone;
    unique case (ph)
      PH_PRE:  ctl.phPre  = 1'b1;
      PH_PIO:  ctl.phPio  = 1'b1;
      PH_CDB:  ctl.phCdb  = 1'b1;
      PH_POST: ctl.phPost = 1'b1;
      PH_DONE: ctl.phDone = 1'b1;
      PH_NCQ:  ctl.phNcq  = 1'b1;
      PH_PKT:  ctl.phPkt  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fault_sort_dp.sv
module fault_sort_dp
  import fault_sort_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  sortCtl_t           ctl,
  input  logic [REG_W-1:0]   statusIn,
  input  logic [REG_W-1:0]   errorIn,
  output logic [NUM_CAT-1:0] catOut,
  output logic [ACT_W-1:0]   actOut,
  output logic               catValid
);
  logic bsy, drdy, drq, err, devErr, hsmHit, decodesErr;
  logic [CAT_IW-1:0]  selIdx;
  logic [NUM_CAT-1:0] nextCat;

  assign bsy    = statusIn[ST_BSY];
  assign drdy   = statusIn[ST_DRDY];
  assign drq    = statusIn[ST_DRQ];
  assign err    = statusIn[ST_ERR];
  assign devErr = ~bsy & err;

  assign hsmHit = (ctl.phPre  & ~(~bsy & drdy & ~drq))
                | (ctl.phPio  & ~bsy & ~drq)
                | (ctl.phCdb  & devErr)
                | (ctl.phDone & drq);

  assign decodesErr = ctl.phPio | ctl.phDone | ctl.phPkt;

  always_comb begin
    selIdx = CAT_IW'(CAT_OK);
    if (ctl.timeout)
      selIdx = ctl.late ? CAT_IW'(CAT_LATE) : CAT_IW'(CAT_UNK);
    else if (hsmHit)
      selIdx = CAT_IW'(CAT_HSM);
    else if (devErr) begin
      if (ctl.phPost)           selIdx = CAT_IW'(CAT_CHK);
      else if (ctl.phNcq)       selIdx = CAT_IW'(CAT_NCQ);
      else if (decodesErr) begin
        if (errorIn[ER_ICRC])      selIdx = CAT_IW'(CAT_BUS);
        else if (errorIn[ER_UNC])  selIdx = CAT_IW'(CAT_MEDIA);
        else if (errorIn[ER_IDNF]) selIdx = CAT_IW'(CAT_ADDR);
        else                       selIdx = CAT_IW'(CAT_OTHER);
      end
    end
  end

  for (genvar g = 0; g < NUM_CAT; g++) begin : g_onehot
    assign nextCat[g] = (selIdx == CAT_IW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      catOut   <= '0;
      actOut   <= '0;
      catValid <= 1'b0;
    end else begin
      catValid <= ctl.capture;
      if (ctl.capture) begin
        catOut <= nextCat;
        actOut <= actionFor(selIdx);
      end
    end
  end
endmodule

// File: rtl/ata_fault_sorter.sv
module ata_fault_sorter
  import fault_sort_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               obsValid,
  input  logic [REG_W-1:0]   statusIn,
  input  logic [REG_W-1:0]   errorIn,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic               timedOut,
  input  logic               cmdDone,
  output logic [NUM_CAT-1:0] catOut,
  output logic [ACT_W-1:0]   actOut,
  output logic               catValid
);
  sortCtl_t ctl;

  fault_sort_ctrl u_ctrl (
    .obsValid(obsValid), .phaseIn(phaseIn), .timedOut(timedOut),
    .cmdDone(cmdDone), .ctl(ctl)
  );

  fault_sort_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .statusIn(statusIn),
    .errorIn(errorIn), .catOut(catOut), .actOut(actOut), .catValid(catValid)
  );
endmodule

// File: rtl/fault_sort_chk.sv
module fault_sort_chk
  import fault_sort_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               obsValid,
  input logic [REG_W-1:0]   statusIn,
  input logic [PHASE_W-1:0] phaseIn,
  input logic               timedOut,
  input logic [NUM_CAT-1:0] catOut,
  input logic [ACT_W-1:0]   actOut,
  input logic               catValid
);
  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    obsValid |=> catValid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !obsValid |=> !catValid);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    catValid |-> $countones(catOut) == 1);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !obsValid |=> $stable(catOut) && $stable(actOut));
  p_pre_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    obsValid && !timedOut && phaseIn == 3'd0 && !statusIn[ST_BSY]
      && statusIn[ST_DRDY] && !statusIn[ST_DRQ] |=> catOut[CAT_OK]);
  p_done_drq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    obsValid && !timedOut && phaseIn == 3'd4 && statusIn[ST_DRQ]
      |=> catOut[CAT_HSM]);
  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    obsValid && timedOut |=> (catOut[CAT_LATE] || catOut[CAT_UNK])
      && actOut == ACT_RESET);
  p_hsm_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
    catValid && catOut[CAT_HSM] |-> actOut == ACT_RESET_SLOW);
endmodule

bind ata_fault_sorter fault_sort_chk u_chk (
  .clk(clk), .rst_n(rst_n), .obsValid(obsValid), .statusIn(statusIn),
  .phaseIn(phaseIn), .timedOut(timedOut), .catOut(catOut),
  .actOut(actOut), .catValid(catValid)
);

// File: tb/sim_ata_fault_sorter.sv
`timescale 1ns/1ps
module sim_ata_fault_sorter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       obsValid = 1'b0;
  logic [7:0] statusIn = '0;
  logic [7:0] errorIn = '0;
  logic [2:0] phaseIn = '0;
  logic       timedOut = 1'b0;
  logic       cmdDone = 1'b0;
  logic [9:0] catOut;
  logic [1:0] actOut;
  logic       catValid;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ata_fault_sorter u0 (
    .clk(clk), .rst_n(rst_n), .obsValid(obsValid), .statusIn(statusIn),
    .errorIn(errorIn), .phaseIn(phaseIn), .timedOut(timedOut),
    .cmdDone(cmdDone), .catOut(catOut), .actOut(actOut), .catValid(catValid)
  );

  // reference: returns category index, tag names the governing requirement
  function automatic int refCat(input logic [2:0] ph, input logic [7:0] st,
                                input logic [7:0] er, input logic to,
                                input logic dn, output string tag);
    logic b, rdy, dq, e;
    b = st[7]; rdy = st[6]; dq = st[3]; e = st[0];
    if (to) begin tag = "R10"; return dn ? 8 : 9; end
    if (ph == 0) begin tag = "R2"; return (!b && rdy && !dq) ? 0 : 1; end
    if (ph == 1 && !b && !dq) begin tag = "R3"; return 1; end
    if (ph == 2 && !b && e) begin tag = "R4"; return 1; end
    if (ph == 4 && dq) begin tag = "R5"; return 1; end
    if (ph == 3 && !b && e) begin tag = "R6"; return 4; end
    if (ph == 5 && !b && e) begin tag = "R7"; return 3; end
    if ((ph == 1 || ph == 4 || ph == 6) && !b && e) begin
      if (er[7]) begin tag = "R8"; return 2; end
      tag = "R9";
      if (er[6]) return 5;
      if (er[4]) return 6;
      return 7;
    end
    tag = "R12";
    return 0;
  endfunction

  function automatic logic [1:0] refAct(input int c);
    if (c == 0) return 2'd0;
    if (c == 1 || c == 2) return 2'd3;
    if (c == 8 || c == 9) return 2'd2;
    return 2'd1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] prevCat;
    logic [1:0] prevAct;
    repeat (3) @(negedge clk);
    checks++;
    if (catOut !== '0 || actOut !== '0 || catValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: cat=%b act=%0d v=%b expected 0/0/0",
               catOut, actOut, catValid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int ph = 0; ph < 8; ph++)
      for (int s = 0; s < 16; s++)
        for (int e = 0; e < 16; e++)
          for (int t = 0; t < 3; t++) begin
            logic [7:0] st, er;
            logic [3:0] fill;
            int expC;
            string tag;
            fill = 4'(s ^ (e * 3) ^ (ph * 5) ^ t);
            st = {s[3], s[2], fill[0], fill[1], s[1], fill[2], fill[3], s[0]};
            er = {e[3], e[2], fill[3], e[1], fill[2], e[0], fill[1], fill[0]};
            statusIn = st; errorIn = er; phaseIn = 3'(ph);
            timedOut = (t != 0); cmdDone = (t == 1) ^ (t == 0 && fill[0]);
            obsValid = 1'b1;
            expC = refCat(3'(ph), st, er, t != 0, t == 1, tag);
            @(negedge clk);
            obsValid = 1'b0;
            checks++;
            if (catValid !== 1'b1 || catOut !== (10'd1 << expC)) begin
              errors++;
              $display("FAIL %s ph=%0d st=%h er=%h t=%0d: cat=%b v=%b expected cat=%b v=1",
                       tag, ph, st, er, t, catOut, catValid, 10'd1 << expC);
            end
            checks++;
            if (actOut !== refAct(expC)) begin
              errors++;
              $display("FAIL R11 cat=%0d: act=%0d expected %0d",
                       expC, actOut, refAct(expC));
            end
            if (e == 5 && t == 0) begin
              // R1: outputs hold with no strobe, inputs changed meanwhile
              prevCat = catOut; prevAct = actOut;
              statusIn = ~st; errorIn = ~er; timedOut = 1'b1;
              @(negedge clk);
              checks++;
              if (catValid !== 1'b0 || catOut !== prevCat || actOut !== prevAct) begin
                errors++;
                $display("FAIL R1 hold: cat=%b act=%0d v=%b expected %b/%0d/0",
                         catOut, actOut, catValid, prevCat, prevAct);
              end
            end
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule